// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor built around one accumulator. Instructions and data share a single memory. Each 16-bit word carries a 4-bit opcode in its upper bits and a 12-bit address in its lower bits. The core moves every instruction through a fixed sequence of phases: fetch, decode, evaluate address, fetch operands, execute, store result. Each phase is a register transfer through the program counter, memory address register, memory data register, instruction register and accumulator.

The memory sits outside the core and is synchronous. A read is requested in one cycle, and its data is captured into the memory data register in the next cycle. Writes happen in a single cycle. A phase controller issues the transfer enables for each phase. A phase that has nothing to do for the current opcode takes one cycle. Four opcodes are defined: halt, load, add and store. The halt opcode parks the core until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is low at a clock edge, the core clears the program counter and accumulator to zero, deasserts halted, and issues no memory write.
- R2: Instruction word layout is opcode in bits [15:12] and address in bits [11:0]. Opcode codes are 0 for halt, 1 for load, 2 for add and 3 for store.
- R3: A load sets the accumulator to the memory word at its address field.
- R4: An add sets the accumulator to the accumulator plus the memory word at its address field, modulo 2^16.
- R5: A store writes the accumulator to memory at its address field in exactly one write cycle. The accumulator is left unchanged.
- R6: A halt sets halted, which stays high until reset. After that, the program counter and accumulator do not change and no memory read or write is issued.
- R7: Timing from reset release, counting clock edges: load, add and store each take 10 cycles. Opcodes 4 to 15 take 9 cycles. A halt raises halted at the 5th edge of its own instruction.
- R8: Instructions are fetched from consecutive addresses starting at 0. The program counter advances by exactly one per fetch, so after a halt at address h it reads h+1.
- R9: Read and write requests are never asserted in the same cycle.
- R10: Opcodes 4 to 15 change neither the accumulator nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_rd | output | 1 | Read request; the memory returns data one cycle later |
| mem_wr | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data (memory data register) |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| halted | output | 1 | Sticky halt indication |
| pc_out | output | 12 | Current program counter |
| acc_out | output | 16 | Current accumulator |

## Verification
The assertions rely on the memory returning read data exactly one cycle after a read request, with no wait states. They also assume reset is held for at least one clock edge, so that the first $past sample after reset is the cleared state. The bench's memory model registers its read data on the same edge that samples the request, so it meets that latency by construction. Every run starts with reset held for two edges, and all program and data words are placed in memory while reset is low.

// File: rtl/acc_core_pkg.sv
// Package: shared types for the accumulator core.
// Holds the phase encoding, the decoded opcode class, the opcode code
// values and the register-transfer enable bundle. Assumes nothing else.
package acc_core_pkg;

    // Opcode code values carried in the upper field of a word.
    localparam int CODE_HALT  = 0;
    localparam int CODE_LOAD  = 1;
    localparam int CODE_ADD   = 2;
    localparam int CODE_STORE = 3;

    // One state per register-transfer step of the instruction cycle.
    typedef enum logic [3:0] {
        PH_FETCH_ADDR,
        PH_FETCH_WAIT,
        PH_FETCH_LOAD,
        PH_FETCH_IR,
        PH_DECODE,
        PH_EVAL_ADDR,
        PH_OPND_READ,
        PH_OPND_LOAD,
        PH_EXECUTE,
        PH_STORE_ACC,
        PH_STORE_WRITE,
        PH_HALTED
    } phase_e;

    // Decoded opcode class.
    typedef enum logic [2:0] {
        OPC_HALT,
        OPC_LOAD,
        OPC_ADD,
        OPC_STORE,
        OPC_NOP
    } op_class_e;

    // Register-transfer enables from the controller to the datapath.
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic ir_load;
        logic pc_inc;
        logic acc_load;
        logic acc_add;
    } xfer_t;

endpackage

// File: rtl/acc_decoder.sv
// Module: opcode decoder.
// Maps the opcode field of the instruction register onto an opcode class.
// Purely combinational. Any code outside the four defined ones is a no-op.
module acc_decoder
    import acc_core_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_e       op_class
);

    // Classify the opcode field.
    always_comb begin
        if (opcode == OP_W'(CODE_HALT))
            op_class = OPC_HALT;
        else if (opcode == OP_W'(CODE_LOAD))
            op_class = OPC_LOAD;
        else if (opcode == OP_W'(CODE_ADD))
            op_class = OPC_ADD;
        else if (opcode == OP_W'(CODE_STORE))
            op_class = OPC_STORE;
        else
            op_class = OPC_NOP;
    end

endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU.
// Operands are the accumulator and the memory data register. The result
// is either the data register passed through (load) or the sum of both
// operands modulo 2^DATA_W (add). Combinational.
module acc_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mdr_in,
    input  logic              add_en,
    output logic [DATA_W-1:0] result
);

    // Select pass-through or sum.
    always_comb begin
        if (add_en)
            result = acc_in + mdr_in;
        else
            result = mdr_in;
    end

endmodule

// File: rtl/acc_phase_ctrl.sv
// Module: phase controller.
// Steps through the instruction-cycle phases and issues the transfer
// enables and memory requests of each phase. Latches the decoded class
// during decode. A phase with nothing to do for the held class takes one
// cycle. Assumes read data arrives one cycle after a read request.
module acc_phase_ctrl
    import acc_core_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  op_class_e dec_class,
    output xfer_t     xfer,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      halted
);

    phase_e    phase_q, phase_d;
    op_class_e op_q;
    logic      needs_read;

    assign needs_read = (op_q == OPC_LOAD) || (op_q == OPC_ADD);

    // Next phase and the transfers of the current phase.
    always_comb begin
        phase_d = phase_q;
        xfer    = '0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        case (phase_q)
            PH_FETCH_ADDR: begin
                xfer.mar_from_pc = 1'b1;
                phase_d = PH_FETCH_WAIT;
            end
            PH_FETCH_WAIT: begin
                mem_rd  = 1'b1;
                phase_d = PH_FETCH_LOAD;
            end
            PH_FETCH_LOAD: begin
                xfer.mdr_from_mem = 1'b1;
                phase_d = PH_FETCH_IR;
            end
            PH_FETCH_IR: begin
                xfer.ir_load = 1'b1;
                xfer.pc_inc  = 1'b1;
                phase_d = PH_DECODE;
            end
            PH_DECODE: begin
                phase_d = (dec_class == OPC_HALT) ? PH_HALTED : PH_EVAL_ADDR;
            end
            PH_EVAL_ADDR: begin
                xfer.mar_from_ir = 1'b1;
                phase_d = PH_OPND_READ;
            end
            PH_OPND_READ: begin
                mem_rd  = needs_read;
                phase_d = needs_read ? PH_OPND_LOAD : PH_EXECUTE;
            end
            PH_OPND_LOAD: begin
                xfer.mdr_from_mem = 1'b1;
                phase_d = PH_EXECUTE;
            end
            PH_EXECUTE: begin
                xfer.acc_load = (op_q == OPC_LOAD);
                xfer.acc_add  = (op_q == OPC_ADD);
                phase_d = PH_STORE_ACC;
            end
            PH_STORE_ACC: begin
                xfer.mdr_from_acc = (op_q == OPC_STORE);
                phase_d = (op_q == OPC_STORE) ? PH_STORE_WRITE : PH_FETCH_ADDR;
            end
            PH_STORE_WRITE: begin
                mem_wr  = 1'b1;
                phase_d = PH_FETCH_ADDR;
            end
            PH_HALTED: begin
                phase_d = PH_HALTED;
            end
            default: begin
                phase_d = PH_FETCH_ADDR;
            end
        endcase
    end

    // Phase register; reset restarts at the fetch address step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_FETCH_ADDR;
        else
            phase_q <= phase_d;
    end

    // Hold the decoded class for the rest of the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_q <= OPC_NOP;
        else if (phase_q == PH_DECODE)
            op_q <= dec_class;
    end

    assign halted = (phase_q == PH_HALTED);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R6
    AST_NO_ACCESS_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr)); // R6
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R9
    AST_WRITE_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer.mdr_from_acc |=> mem_wr); // R5

endmodule

// File: rtl/acc_datapath.sv
// Module: datapath registers.
// Holds the program counter, memory address and data registers, the
// instruction register and the accumulator, and applies the enables from
// the controller. The memory address and write data come straight from
// the address and data registers. Reset clears every register.
module acc_datapath
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int ADDR_W = DATA_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_t             xfer,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [OP_W-1:0]   ir_op,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc
);

    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mdr;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] alu_y;

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .acc_in (acc),
        .mdr_in (mdr),
        .add_en (xfer.acc_add),
        .result (alu_y)
    );

    // Program counter: advances by one at the end of fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (xfer.pc_inc)
            pc <= pc + 1'b1;
    end

    // Memory address register: from the program counter or the address field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mar <= '0;
        else if (xfer.mar_from_pc)
            mar <= pc;
        else if (xfer.mar_from_ir)
            mar <= ir[ADDR_W-1:0];
    end

    // Memory data register: from read data or from the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mdr <= '0;
        else if (xfer.mdr_from_mem)
            mdr <= mem_rdata;
        else if (xfer.mdr_from_acc)
            mdr <= acc;
    end

    // Instruction register: copied from the data register during fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir <= '0;
        else if (xfer.ir_load)
            ir <= mdr;
    end

    // Accumulator: takes the ALU result on load or add.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (xfer.acc_load || xfer.acc_add)
            acc <= alu_y;
    end

    assign ir_op     = ir[DATA_W-1:DATA_W-OP_W];
    assign mem_addr  = mar;
    assign mem_wdata = mdr;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pc == $past(pc)) || (pc == $past(pc) + 1'b1))); // R8
    AST_IR_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        xfer.ir_load |-> $past(xfer.mdr_from_mem)); // R8

endmodule

// File: rtl/acc_core.sv
// Module: multicycle accumulator processor core (top).
// Connects the phase controller, the decoder and the datapath. Memory is
// external and synchronous: read data must be valid in the cycle after
// mem_rd, and a write takes effect at the edge that ends the mem_wr cycle.
module acc_core
    import acc_core_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int OP_W   = 4,
    localparam int ADDR_W = DATA_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] acc_out
);

    xfer_t           xfer;
    op_class_e       dec_class;
    logic [OP_W-1:0] ir_op;

    acc_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_class (dec_class),
        .xfer      (xfer),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    acc_decoder #(.OP_W(OP_W)) u_dec (
        .opcode   (ir_op),
        .op_class (dec_class)
    );

    acc_datapath #(
        .DATA_W (DATA_W),
        .OP_W   (OP_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .mem_rdata (mem_rdata),
        .ir_op     (ir_op),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc        (pc_out),
        .acc       (acc_out)
    );

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_out)); // R6
    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(acc_out)); // R6
    AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == acc_out)); // R5
    AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(acc_out)); // R5

endmodule

// File: tb/acc_core_test.sv
`timescale 1ns/100ps
module acc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;
    logic [11:0] pc_out;
    logic [15:0] acc_out;

    logic [15:0] mem [0:255];
    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .pc_out(pc_out), .acc_out(acc_out)
    );

    // Synchronous memory model: one cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_wr) wr_cnt <= wr_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input int op, input int addr);
        return {op[3:0], addr[11:0]};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    endtask

    // Reset, release, and count edges until halted is seen.
    task automatic run_prog(output int cyc);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_cnt = 0;
        rst_n = 1'b1;
        cyc = 0;
        while (cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
        end
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] a, b, s, exp_acc, p_acc;
        logic [11:0] p_pc;
        int w0;

        // R1: reset state
        clear_mem();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_out == 0, "R1 pc", pc_out, 0);
        check(acc_out == 0, "R1 acc", acc_out, 0);
        check(halted == 0, "R1 halted", halted, 0);
        check(mem_wr == 0, "R1 write", mem_wr, 0);

        // R6 R7 R8: halt at address 0
        clear_mem();
        mem[0] = word(0, 0);
        run_prog(cyc);
        check(cyc == 5, "R7 halt cycles", cyc, 5);
        check(pc_out == 1, "R8 pc after halt", pc_out, 1);
        check(acc_out == 0, "R6 acc", acc_out, 0);

        // R2 R3 R4 R5 R7: sweep load/add/store over operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = (i == 7) ? 16'hFFFF : 16'((i * 40503 + 7) & 16'hFFFF);
                b = 16'((j * 9973 + 1) & 16'hFFFF);
                s = a + b;
                clear_mem();
                mem[0] = word(1, 8'h20);
                mem[1] = word(2, 8'h21);
                mem[2] = word(3, 8'h22);
                mem[3] = word(0, 0);
                mem[8'h20] = a;
                mem[8'h21] = b;
                run_prog(cyc);
                check(acc_out == s, "R4 sum", acc_out, s);
                check(mem[8'h22] == s, "R5 stored", mem[8'h22], s);
                check(mem[8'h20] == a, "R3 source kept", mem[8'h20], a);
                check(cyc == 35, "R7 cycles", cyc, 35);
                check(pc_out == 4, "R8 pc", pc_out, 4);
                check(wr_cnt == 1, "R5 one write", wr_cnt, 1);
            end
        end

        // R6: frozen after halt
        p_pc = pc_out;
        p_acc = acc_out;
        w0 = wr_cnt;
        repeat (30) @(negedge clk);
        check(halted == 1, "R6 sticky", halted, 1);
        check(pc_out == p_pc, "R6 pc frozen", pc_out, p_pc);
        check(acc_out == p_acc, "R6 acc frozen", acc_out, p_acc);
        check(wr_cnt == w0, "R6 no write", wr_cnt, w0);

        // R3 R4 R7: add chains of varying length
        for (int k = 1; k <= 10; k++) begin
            clear_mem();
            mem[0] = word(1, 8'h40);
            mem[8'h40] = 16'h1234;
            exp_acc = 16'h1234;
            for (int n = 1; n <= k; n++) begin
                mem[n] = word(2, 8'h40 + n);
                mem[8'h40 + n] = 16'(n * 7919);
                exp_acc = exp_acc + 16'(n * 7919);
            end
            mem[k + 1] = word(3, 8'h60);
            mem[k + 2] = word(0, 0);
            run_prog(cyc);
            check(acc_out == exp_acc, "R4 chain acc", acc_out, exp_acc);
            check(mem[8'h60] == exp_acc, "R5 chain store", mem[8'h60], exp_acc);
            check(cyc == 10 * (k + 2) + 5, "R7 chain cycles", cyc, 10 * (k + 2) + 5);
            check(pc_out == 12'(k + 3), "R8 chain pc", pc_out, k + 3);
        end

        // R10 R7: undefined opcodes 4..15
        for (int op = 4; op < 16; op++) begin
            clear_mem();
            mem[0] = word(1, 8'h30);
            mem[1] = word(op, 8'h30);
            mem[2] = word(0, 0);
            mem[8'h30] = 16'h0A5A;
            run_prog(cyc);
            check(acc_out == 16'h0A5A, "R10 acc kept", acc_out, 16'h0A5A);
            check(mem[8'h30] == 16'h0A5A, "R10 mem kept", mem[8'h30], 16'h0A5A);
            check(wr_cnt == 0, "R10 no write", wr_cnt, 0);
            check(cyc == 24, "R7 nop cycles", cyc, 24);
        end

        // R1: reset in mid-run clears state
        clear_mem();
        mem[0] = word(1, 8'h10);
        mem[1] = word(2, 8'h10);
        mem[2] = word(0, 0);
        mem[8'h10] = 16'h00C3;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (13) @(negedge clk);
        check(acc_out == 16'h00C3, "R3 mid load", acc_out, 16'h00C3);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(pc_out == 0, "R1 mid pc", pc_out, 0);
        check(acc_out == 0, "R1 mid acc", acc_out, 0);
        check(halted == 0, "R1 mid halted", halted, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule